// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is an up-counting timer with a single compare channel. Software reaches it over a flat register bus with an address, a write strobe, write data and combinational read data. A control word starts and stops the count and chooses what advances the counter. The choices are the bus clock itself, a peripheral-rate strobe, or a crystal strobe. The crystal strobe passes through its own divider, which is either a fixed divide-by-8 or a programmable divider.

When an advance of the counter lands on the compare value, a sticky flag is set. Software clears the flag by writing a one to it. A separate enable bit decides whether the flag drives the interrupt line. The counter either runs freely through the compare value and wraps at its all-ones value, or it restarts from zero on the advance that follows a match. The counter width is a parameter, 32 bits by default, and narrower counters read back zero-extended.

Top module: `match_timer`

## Requirements
- R1: After reset the compare register reads all ones (for the counter width), and every other register reads zero. The interrupt output is low.
- R2: Control bit 0 is the run bit. While it is clear the counter holds its value on every clock.
- R3: Control bits 8:6 pick the advance source. Value 1 advances on every clock, value 2 on each cycle where `per_stb` is high, and value 5 on each output pulse of the crystal divider. Any other value never advances the counter.
- R4: With control bit 9 set (free-run), the counter continues past a match, and it goes from its all-ones value to 0.
- R5: With control bit 9 clear (restart), the advance that follows a cycle where the counter equals the compare value loads 0.
- R6: Control bit 10 clear gives a crystal divider of 8 `xtal_stb` pulses per advance. With bit 10 set, the divider is the prescaler register bits 15:12 plus one, so a zero prescaler gives one advance per strobe.
- R7: Status bit 0 (offset 0x08) is set on the edge where an advance makes the counter equal to the compare value. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R8: When a match and a write-1-to-clear fall on the same edge, the flag ends set.
- R9: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 (offset 0x0C) are both set. Clearing the enable leaves the flag set.
- R10: Control bit 3 is stored and reads back, and counting proceeds unchanged while it is set.
- R11: Offsets are control 0x00, prescaler 0x04, status 0x08, enable 0x0C, compare 0x10 and counter 0x24. Writes to the counter are ignored. Unused bits and unmapped offsets read zero.
- R12: A compare value written behind the current count produces no match until the counter wraps round to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| per_stb | input | 1 | Peripheral-rate advance strobe |
| xtal_stb | input | 1 | Crystal-rate strobe into the divider |
| irq | output | 1 | Compare interrupt, flag AND enable |

## Verification
A register write takes effect on the edge that samples it. Because reads are combinational, the new value shows on `bus_rdata` one cycle after the write is driven. An advance updates the counter and raises the flag on the same edge. An input strobe sampled at edge N therefore shows in the count and status read at the following falling edge. `irq` follows the flag and enable with no extra register stage. The bench drives inputs just after each rising edge and compares against its model at every falling edge, so each result is checked in the cycle it is due. Directed checks measure counter differences across a known number of rising edges, which keeps them exact without depending on absolute start times.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int DATA_W    = 32;
    localparam int XDIV_W    = 4;
    localparam int XPRE_LSB  = 12;

    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_XPRE  = 'h04;
    localparam int OFS_STAT  = 'h08;
    localparam int OFS_IEN   = 'h0C;
    localparam int OFS_CMP   = 'h10;
    localparam int OFS_CNT   = 'h24;

    localparam logic [DATA_W-1:0] CTRL_WMASK = 32'h0000_07C9;
    localparam logic [DATA_W-1:0] XPRE_WMASK = 32'h0000_F000;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_BUS  = 3'd1,
        SRC_PER  = 3'd2,
        SRC_XTAL = 3'd5
    } src_e;

    typedef struct packed {
        logic [20:0] rsvd_hi;
        logic        xdiv_en;
        logic        free_run;
        logic [2:0]  src;
        logic [1:0]  rsvd_mid;
        logic        wait_en;
        logic [1:0]  rsvd_lo;
        logic        run;
    } ctrl_t;

    function automatic logic [XDIV_W-1:0] xdiv_limit(
        input logic              en,
        input logic [XDIV_W-1:0] pre,
        input int                fixed_div
    );
        return en ? pre : XDIV_W'(fixed_div - 1);
    endfunction

    function automatic logic addr_hit(input logic [7:0] a, input int ofs);
        return a == 8'(ofs);
    endfunction

endpackage

// File: rtl/tmr_tick_sel.sv
`timescale 1ns/1ps
module tmr_tick_sel
    import tmr_pkg::*;
#(
    parameter int FIXED_DIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [2:0]        src,
    input  logic              xdiv_en,
    input  logic [XDIV_W-1:0] xpre,
    input  logic              per_stb,
    input  logic              xtal_stb,
    output logic              tick
);
    logic [XDIV_W-1:0] xcnt_q;
    logic [XDIV_W-1:0] lim;
    logic              xtal_tick;
    logic              xtal_sel;

    assign xtal_sel  = (src == SRC_XTAL);
    assign lim       = xdiv_limit(xdiv_en, xpre, FIXED_DIV);
    assign xtal_tick = xtal_stb && (xcnt_q >= lim);

    always_ff @(posedge clk) begin
        if (rst || !run || !xtal_sel) begin
            xcnt_q <= '0;
        end else if (xtal_stb) begin
            xcnt_q <= xtal_tick ? '0 : XDIV_W'(xcnt_q + 1'b1);
        end
    end

    always_comb begin
        case (src_e'(src))
            SRC_BUS:  tick = 1'b1;
            SRC_PER:  tick = per_stb;
            SRC_XTAL: tick = xtal_tick;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_count.sv
`timescale 1ns/1ps
module tmr_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             free_run,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] count,
    output logic             match_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             adv;

    assign adv = run && tick;
    assign nxt = (!free_run && (cnt_q == cmp)) ? '0 : cnt_q + CNT_W'(1);
    assign match_evt = adv && (nxt == cmp);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv) begin
            cnt_q <= nxt;
        end
    end
endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              match_evt,
    output ctrl_t             ctrl_q,
    output logic [XDIV_W-1:0] xpre_q,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              flag_q,
    output logic              ien_q,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [7:0] a8;
    logic wr_ctrl, wr_xpre, wr_stat, wr_ien, wr_cmp;

    assign a8      = 8'(bus_addr);
    assign wr_ctrl = bus_we && addr_hit(a8, OFS_CTRL);
    assign wr_xpre = bus_we && addr_hit(a8, OFS_XPRE);
    assign wr_stat = bus_we && addr_hit(a8, OFS_STAT);
    assign wr_ien  = bus_we && addr_hit(a8, OFS_IEN);
    assign wr_cmp  = bus_we && addr_hit(a8, OFS_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            xpre_q <= '0;
            cmp_q  <= '1;
            ien_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata & CTRL_WMASK);
            if (wr_xpre) xpre_q <= bus_wdata[XPRE_LSB +: XDIV_W];
            if (wr_ien)  ien_q  <= bus_wdata[0];
            if (wr_cmp)  cmp_q  <= bus_wdata[CNT_W-1:0];
            if (match_evt)                  flag_q <= 1'b1;
            else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = DATA_W'(ctrl_q);
        if (bus_addr == ADDR_W'(OFS_XPRE)) bus_rdata = DATA_W'(xpre_q) << XPRE_LSB;
        if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = DATA_W'(flag_q);
        if (bus_addr == ADDR_W'(OFS_IEN))  bus_rdata = DATA_W'(ien_q);
        if (bus_addr == ADDR_W'(OFS_CMP))  bus_rdata = DATA_W'(cmp_q);
        if (bus_addr == ADDR_W'(OFS_CNT))  bus_rdata = DATA_W'(count);
    end

    assign irq = flag_q & ien_q;
endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 8,
    parameter int FIXED_XDIV = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              per_stb,
    input  logic              xtal_stb,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [XDIV_W-1:0] xpre_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [CNT_W-1:0]  count_w;
    logic              flag_q, ien_q, tick_w, match_w, run_w, free_w;

    assign run_w  = ctrl_q.run;
    assign free_w = ctrl_q.free_run;

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .count(count_w), .match_evt(match_w),
        .ctrl_q(ctrl_q), .xpre_q(xpre_q), .cmp_q(cmp_q), .flag_q(flag_q),
        .ien_q(ien_q), .bus_rdata(bus_rdata), .irq(irq)
    );

    tmr_tick_sel #(.FIXED_DIV(FIXED_XDIV)) tick_i (
        .clk(clk), .rst(rst), .run(run_w), .src(ctrl_q.src),
        .xdiv_en(ctrl_q.xdiv_en), .xpre(xpre_q), .per_stb(per_stb),
        .xtal_stb(xtal_stb), .tick(tick_w)
    );

    tmr_count #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst(rst), .run(run_w), .tick(tick_w), .free_run(free_w),
        .cmp(cmp_q), .count(count_w), .match_evt(match_w)
    );
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              wbit0,
    input logic              run,
    input logic              tick,
    input logic              free_run,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  cmp,
    input logic              match_evt,
    input logic              flag,
    input logic              ien,
    input logic              irq
);
    logic clr_req;
    assign clr_req = bus_we && (bus_addr == ADDR_W'(OFS_STAT)) && wbit0;

    // R2
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(count));
    // R4
    free_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && free_run && (&count)) |=> (count == '0));
    // R5
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !free_run && (count == cmp)) |=> (count == '0));
    // R7
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !match_evt) |=> !flag);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> flag);
    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag && ien));
endmodule

bind match_timer tmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .wbit0(bus_wdata[0]), .run(run_w), .tick(tick_w), .free_run(free_w),
    .count(count_w), .cmp(cmp_q), .match_evt(match_w), .flag(flag_q),
    .ien(ien_q), .irq(irq)
);

// File: tb/match_timer_tb_top.sv
`timescale 1ns/1ps
module match_timer_tb_top;
    localparam int CW = 10;
    localparam int unsigned MASK = (1 << CW) - 1;

    logic clk = 0, rst = 1, bus_we = 0, per_stb = 0, xtal_stb = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    match_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .per_stb(per_stb),
        .xtal_stb(xtal_stb), .irq(irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int unsigned m_ctrl = 0, m_pre = 0, m_ien = 0, m_cmp = MASK, m_cnt = 0, m_xc = 0;
    bit m_flag = 0, m_live = 0;

    function automatic int unsigned m_rd(input int unsigned a);
        case (a)
            'h00: return m_ctrl;
            'h04: return m_pre;
            'h08: return m_flag;
            'h0C: return m_ien;
            'h10: return m_cmp;
            'h24: return m_cnt;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        bit run, xt, tk, mt;
        int unsigned src, lim;
        m_live = 1;
        if (rst) begin
            m_ctrl = 0; m_pre = 0; m_ien = 0; m_cmp = MASK; m_cnt = 0; m_xc = 0; m_flag = 0;
        end else begin
            run = m_ctrl[0];
            src = (m_ctrl >> 6) & 7;
            xt = 0; mt = 0;
            if (!run || src != 5) m_xc = 0;
            else if (xtal_stb) begin
                lim = m_ctrl[10] ? ((m_pre >> 12) & 15) : 7;
                if (m_xc >= lim) begin xt = 1; m_xc = 0; end
                else m_xc++;
            end
            tk = (src == 1) ? 1 : (src == 2) ? per_stb : (src == 5) ? xt : 0;
            if (run && tk) begin
                if (!m_ctrl[9] && m_cnt == m_cmp) m_cnt = 0;
                else m_cnt = (m_cnt + 1) & MASK;
                mt = (m_cnt == m_cmp);
            end
            if (bus_we) begin
                case (bus_addr)
                    'h00: m_ctrl = bus_wdata & 32'h7C9;
                    'h04: m_pre  = bus_wdata & 32'hF000;
                    'h08: if (bus_wdata[0]) m_flag = 0;
                    'h0C: m_ien  = bus_wdata & 1;
                    'h10: m_cmp  = bus_wdata & MASK;
                    default: ;
                endcase
            end
            if (mt) m_flag = 1;
        end
    end

    always @(negedge clk) begin
        if (m_live && !done) begin
            check("R11 rdata vs model", bus_rdata, m_rd(bus_addr));
            check("R9 irq vs model", {31'd0, irq}, {31'd0, m_flag & m_ien[0]});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1 bus_addr = a; bus_we = 1; bus_wdata = d;
        @(posedge clk); #1 bus_we = 0; bus_wdata = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] v);
        @(posedge clk); #1 bus_addr = a;
        @(negedge clk); v = bus_rdata;
    endtask

    task automatic measure(input int n, input int np, input int nx, output int unsigned d);
        logic [31:0] a, b;
        peek(8'h24, a);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 per_stb = (i < np); xtal_stb = (i < nx);
        end
        @(posedge clk); #1 per_stb = 0; xtal_stb = 0;
        @(negedge clk); b = bus_rdata;
        d = (b - a) & MASK;
    endtask

    task automatic do_reset();
        @(posedge clk); #1 rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
    endtask

    task automatic poll(input logic [7:0] a, input logic [31:0] val, input int max, output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < max; i++) begin
            peek(a, v);
            if (v == val) begin ok = 1; break; end
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, prev;
        int unsigned d;
        int ones;
        bit ok;
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1 reset values
        peek(8'h10, v); check("R1 compare reset", v, MASK);
        peek(8'h00, v); check("R1 control reset", v, 0);
        peek(8'h24, v); check("R1 counter reset", v, 0);
        check("R1 irq reset", {31'd0, irq}, 0);

        // R11 map details
        wr(8'h24, 32'h123); peek(8'h24, v); check("R11 counter write ignored", v, 0);
        peek(8'h30, v); check("R11 unmapped reads zero", v, 0);
        wr(8'h00, 32'hFFFF_FFFE); peek(8'h00, v); check("R11 control reserved bits", v, 32'h7C8);
        wr(8'h04, 32'hFFFF_FFFF); peek(8'h04, v); check("R11 prescaler reserved bits", v, 32'hF000);
        wr(8'h04, 0); wr(8'h00, 0);

        // R3 bus clock source, R2 disabled hold
        wr(8'h00, 32'h041); measure(5, 0, 0, d); check("R3 bus source every clock", d, 6);
        wr(8'h00, 32'h040); measure(5, 5, 5, d); check("R2 counter holds when off", d, 0);
        // R10 wait bit
        wr(8'h00, 32'h049); peek(8'h00, v); check("R10 wait bit readback", v, 32'h049);
        measure(5, 0, 0, d); check("R10 counting with wait bit", d, 6);
        // R3 peripheral strobe and unlisted source
        wr(8'h00, 32'h081); measure(5, 3, 0, d); check("R3 peripheral strobe count", d, 3);
        wr(8'h00, 32'h0C1); measure(5, 5, 5, d); check("R3 unlisted source idle", d, 0);
        // R6 crystal divider
        wr(8'h00, 32'h141); measure(16, 0, 16, d); check("R6 fixed crystal divide 8", d, 2);
        wr(8'h04, 32'h7000); wr(8'h00, 32'h541); measure(16, 0, 16, d);
        check("R6 programmed divide 8", d, 2);
        wr(8'h04, 32'h1000); measure(16, 0, 16, d); check("R6 programmed divide 2", d, 8);
        wr(8'h04, 32'h0000); measure(16, 0, 16, d); check("R6 zero prescaler no division", d, 16);

        // R4 / R7 / R9 in free-run mode
        do_reset();
        wr(8'h10, 32'h20); wr(8'h00, 32'h241);
        poll(8'h08, 1, 100, ok); check("R7 flag raised at match", {31'd0, ok}, 1);
        peek(8'h24, v); check("R4 free-run continues past match", v, 32'h21);
        wr(8'h0C, 1); peek(8'h08, v); check("R9 irq with enable", {31'd0, irq}, 1);
        wr(8'h0C, 0); peek(8'h08, v); check("R9 mask keeps flag", v, 1);
        check("R9 irq masked", {31'd0, irq}, 0);
        wr(8'h08, 0); peek(8'h08, v); check("R7 write zero keeps flag", v, 1);
        wr(8'h08, 1); peek(8'h08, v); check("R7 write one clears flag", v, 0);
        peek(8'h24, prev); ok = 0;
        for (int i = 0; i < 1200; i++) begin
            peek(8'h24, v);
            if (v < prev) begin
                check("R4 wrap from all ones", prev, MASK);
                check("R4 wrap to zero", v, 0);
                ok = 1; break;
            end
            prev = v;
        end
        check("R4 wrap observed", {31'd0, ok}, 1);

        // R5 restart mode
        do_reset();
        wr(8'h10, 32'h20); wr(8'h00, 32'h041);
        poll(8'h08, 1, 100, ok); check("R5 match reached", {31'd0, ok}, 1);
        peek(8'h24, v); check("R5 restart loads zero", v, 0);

        // R8 set beats clear
        do_reset();
        wr(8'h10, 32'h3); wr(8'h00, 32'h041);
        @(posedge clk); #1 bus_addr = 8'h08; bus_we = 1; bus_wdata = 1;
        ones = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); @(negedge clk); ones += bus_rdata[0];
        end
        @(posedge clk); #1 bus_we = 0; bus_wdata = 0;
        check("R8 set wins over clear", ones, 2);

        // R12 compare behind the count
        do_reset();
        wr(8'h00, 32'h241);
        repeat (80) @(posedge clk);
        wr(8'h10, 32'h10); wr(8'h08, 1);
        ones = 0;
        for (int i = 0; i < 200; i++) begin
            peek(8'h08, v); ones += v[0];
        end
        check("R12 no match before wrap", ones, 0);
        poll(8'h08, 1, 1200, ok); check("R12 match after wrap", {31'd0, ok}, 1);

        done = 1;
        summary();
        $finish;
    end
endmodule